// File: doc/BRIEF.md
# Synchronization Status Frame Parser

This block sits behind an Ethernet MAC receive path and watches its byte-wide stream (data, valid, start and end markers, and a good/bad flag on the last byte). It picks out the slow-protocol frames that carry a clock quality level. A frame qualifies when three header checks all pass: the slow-protocol multicast destination address, the slow-protocol length/type value, and the organization-specific subtype byte. From each qualifying frame it extracts a 4-bit quality level and a flag that tells an event-driven frame from a periodic heartbeat. It reports both with a single-cycle strobe.

A frame is reported only if the MAC marks it good at its last byte and it is long enough to contain the quality byte. Any other frame is dropped without a trace. The outputs keep their last reported values between strobes.

Alongside the parser, a heartbeat supervisor counts pulses of a tick-enable input. If a configured number of ticks passes with no accepted frame, it raises a timeout flag. The next accepted frame clears the flag, so clock-selection logic downstream can treat a silent port as having lost its quality information.

Top module: `sync_status_rx`

## Requirements
- R1: A frame is accepted only if bytes 0..5 (byte 0 is the byte with the start marker) equal 01 80 C2 00 00 02. Bytes 6..11 (source address) may hold any value.
- R2: A frame is accepted only if bytes 12 and 13 equal 88 and 09.
- R3: A frame is accepted only if byte 14 equals 0A.
- R4: For an accepted frame, `ql_o` takes the low nibble of byte QL_POS (default 22). `strobe_o` is high for exactly the one cycle after the clock edge that takes in the last byte.
- R5: For an accepted frame, `event_o` takes bit 3 of byte FLAG_POS (default 18).
- R6: A frame whose last byte arrives with `rx_good_i` low is dropped: no strobe, and the outputs are unchanged.
- R7: A frame that ends before byte QL_POS is dropped, whatever its contents.
- R8: `ql_o` and `event_o` change only together with `strobe_o` and hold their values between strobes.
- R9: After reset, or after the last accepted frame, `timeout_o` rises in the cycle after the TIMEOUT_TICKS-th cycle in which `tick_i` is high.
- R10: `timeout_o` is low in the cycle after a strobe, and the tick count restarts from zero at that strobe.
- R11: Cycles with `rx_valid_i` low do not advance the byte position. A start marker inside a frame restarts parsing at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Byte qualifier |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_good_i | input | 1 | Frame good, sampled with last byte |
| tick_i | input | 1 | Heartbeat time-base enable |
| strobe_o | output | 1 | One-cycle report of an accepted frame |
| ql_o | output | 4 | Quality level of last accepted frame |
| event_o | output | 1 | Event flag of last accepted frame |
| timeout_o | output | 1 | No accepted frame within the tick window |

## Verification
The bench sweeps all 32 combinations of quality nibble and event bit. It then flips each checked header byte in turn, which catches a matcher that skips a byte or checks the wrong position, and it varies the source address to catch a matcher that is too strict. Frame lengths around the quality byte are swept, because an off-by-one in the length rule would either report a truncated frame or drop a minimal one. Idle gaps inside a frame and a restart marker in the middle of a frame catch a position counter that drifts. The timeout is probed one tick short of the window and exactly at it, and again after a strobe, so a timer that is off by one or never restarts is reported.

// File: rtl/sync_status_pkg.sv
package sync_status_pkg;
  localparam int unsigned HDR_BYTES = 15;
  localparam logic [119:0] HDR_VAL  = {48'h0180C2000002, 48'h0, 16'h8809, 8'h0A};
  localparam logic [119:0] HDR_CARE = {48'hFFFFFFFFFFFF, 48'h0, 16'hFFFF, 8'hFF};

  function automatic logic hdr_byte_ok(int unsigned idx, logic [7:0] b);
    logic [7:0] v;
    logic [7:0] m;
    v = HDR_VAL[119 - 8*idx -: 8];
    m = HDR_CARE[119 - 8*idx -: 8];
    return ((b ^ v) & m) == 8'h00;
  endfunction
endpackage

// File: rtl/ssr_byte_track.sv
module ssr_byte_track #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned IDX_MAX = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             beat_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             in_frame_q;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] cur_idx;

  assign beat_o  = valid_i && (sof_i || in_frame_q);
  assign last_o  = beat_o && eof_i;
  assign cur_idx = sof_i ? '0 : cnt_q;
  assign idx_o   = cur_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (beat_o) begin
      in_frame_q <= !eof_i;
      cnt_q      <= (cur_idx == IDX_W'(IDX_MAX)) ? cur_idx : cur_idx + 1'b1;
    end
  end

  // R11
  idx_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
endmodule

// File: rtl/ssr_hdr_match.sv
module ssr_hdr_match
  import sync_status_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             ok_o
);
  logic ok_q;
  logic in_hdr;
  logic byte_ok;

  assign in_hdr  = 32'(idx_i) < HDR_BYTES;
  assign byte_ok = in_hdr ? hdr_byte_ok(32'(idx_i), data_i) : 1'b1;
  assign ok_o    = ((idx_i == '0) ? 1'b1 : ok_q) && byte_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ok_q <= 1'b0;
    else if (beat_i) ok_q <= ok_o;
  end

  // R1
  hdr_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ok_q) |-> $past(beat_i));
endmodule

// File: rtl/ssr_field_cap.sv
module ssr_field_cap #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned FLAG_POS = 18,
  parameter int unsigned QL_POS = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [3:0]       ql_o,
  output logic             evt_o,
  output logic             reach_o
);
  logic [3:0] ql_q;
  logic       evt_q;
  logic       at_ql;
  logic       at_flag;

  assign at_ql   = idx_i == IDX_W'(QL_POS);
  assign at_flag = idx_i == IDX_W'(FLAG_POS);
  assign ql_o    = at_ql ? data_i[3:0] : ql_q;
  assign evt_o   = at_flag ? data_i[3] : evt_q;
  assign reach_o = idx_i >= IDX_W'(QL_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ql_q  <= '0;
      evt_q <= 1'b0;
    end else if (beat_i) begin
      if (at_ql)   ql_q  <= data_i[3:0];
      if (at_flag) evt_q <= data_i[3];
    end
  end
endmodule

// File: rtl/ssr_hb_timer.sv
module ssr_hb_timer #(
  parameter int unsigned TIMEOUT_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic timeout_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1);
  logic [CW-1:0] cnt_q;
  logic          to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (tick_i && !to_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == CW'(TIMEOUT_TICKS)) to_q <= 1'b1;
    end
  end

  assign timeout_o = to_q;

  // R9
  to_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> $past(tick_i));
  // R10
  to_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !to_q);
endmodule

// File: rtl/sync_status_rx.sv
module sync_status_rx #(
  parameter int unsigned FLAG_POS = 18,
  parameter int unsigned QL_POS = 22,
  parameter int unsigned TIMEOUT_TICKS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  input  logic       rx_sof_i,
  input  logic       rx_eof_i,
  input  logic       rx_good_i,
  input  logic       tick_i,
  output logic       strobe_o,
  output logic [3:0] ql_o,
  output logic       event_o,
  output logic       timeout_o
);
  localparam int unsigned IDX_MAX = QL_POS + 1;
  localparam int unsigned IDX_W = $clog2(IDX_MAX + 1) < 5 ? 5 : $clog2(IDX_MAX + 1);

  logic             beat;
  logic             last;
  logic [IDX_W-1:0] idx;
  logic             hdr_ok;
  logic [3:0]       ql_now;
  logic             evt_now;
  logic             reach;
  logic             accept;
  logic             stb_q;
  logic [3:0]       ql_q;
  logic             evt_q;

  ssr_byte_track #(.IDX_W(IDX_W), .IDX_MAX(IDX_MAX)) u_track (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .sof_i(rx_sof_i), .eof_i(rx_eof_i),
    .beat_o(beat), .last_o(last), .idx_o(idx)
  );

  ssr_hdr_match #(.IDX_W(IDX_W)) u_hdr (
    .clk_i, .rst_ni, .beat_i(beat), .idx_i(idx), .data_i(rx_data_i), .ok_o(hdr_ok)
  );

  ssr_field_cap #(.IDX_W(IDX_W), .FLAG_POS(FLAG_POS), .QL_POS(QL_POS)) u_fld (
    .clk_i, .rst_ni, .beat_i(beat), .idx_i(idx), .data_i(rx_data_i),
    .ql_o(ql_now), .evt_o(evt_now), .reach_o(reach)
  );

  assign accept = last && rx_good_i && hdr_ok && reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      ql_q  <= '0;
      evt_q <= 1'b0;
    end else begin
      stb_q <= accept;
      if (accept) begin
        ql_q  <= ql_now;
        evt_q <= evt_now;
      end
    end
  end

  ssr_hb_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_hb (
    .clk_i, .rst_ni, .tick_i, .clr_i(stb_q), .timeout_o
  );

  assign strobe_o = stb_q;
  assign ql_o     = ql_q;
  assign event_o  = evt_q;

  // R4
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  // R6
  stb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(rx_valid_i && rx_eof_i && rx_good_i));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> ($stable(ql_o) && $stable(event_o)));
endmodule

// File: tb/sim_sync_status_rx.sv
module sim_sync_status_rx;
  localparam int TO = 6;
  logic clk = 0, rst_n = 0;
  logic [7:0] data = 0;
  logic valid = 0, sof = 0, eof = 0, good = 0, tick = 0;
  logic stb, ev, to;
  logic [3:0] ql;
  int checks = 0, errors = 0;
  logic [7:0] fr [0:39];
  logic [3:0] last_ql = 0;
  logic last_ev = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_status_rx #(.TIMEOUT_TICKS(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(data), .rx_valid_i(valid),
    .rx_sof_i(sof), .rx_eof_i(eof), .rx_good_i(good), .tick_i(tick),
    .strobe_o(stb), .ql_o(ql), .event_o(ev), .timeout_o(to)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(logic [3:0] q, logic e, int seed);
    logic [47:0] da = 48'h0180C2000002;
    for (int i = 0; i < 40; i++) fr[i] = 8'(8'h30 + i * 7);
    for (int i = 0; i < 6; i++) fr[i] = da[47 - 8*i -: 8];
    for (int i = 6; i < 12; i++) fr[i] = 8'(seed * 13 + i);
    fr[12] = 8'h88; fr[13] = 8'h09; fr[14] = 8'h0A;
    fr[18] = {4'hA, e, 3'b101} ^ {4'(seed), 4'h0};
    fr[22] = {4'(seed + 5), q};
  endtask

  // sends len bytes, then samples at the negedge after the last edge
  task automatic send(int len, bit g, bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); valid = 0; sof = 0; eof = 0; data = 8'hFF;
      end
      @(negedge clk);
      valid = 1; data = fr[i]; sof = (i == 0); eof = (i == len - 1); good = g;
    end
    @(negedge clk);
    valid = 0; sof = 0; eof = 0; good = 0;
  endtask

  task automatic expect_frame(string req, bit acc, logic [3:0] q, logic e);
    chk({req, " strobe"}, int'(stb), int'(acc));
    if (acc) begin last_ql = q; last_ev = e; end
    chk({req, " ql"}, int'(ql), int'(last_ql));
    chk({req, " event"}, int'(ev), int'(last_ev));
    @(negedge clk);
    chk({req, " pulse width"}, int'(stb), 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset strobe", int'(stb), 0);
    chk("reset ql", int'(ql), 0);
    chk("reset timeout", int'(to), 0);

    // R9: one tick short, then exactly the window
    for (int i = 0; i < TO; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      chk("R9 timeout level", int'(to), int'(i == TO - 1));
    end
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    chk("R9 timeout holds", int'(to), 1);

    // R4 R5 sweep
    for (int q = 0; q < 16; q++)
      for (int e = 0; e < 2; e++) begin
        build(4'(q), e[0], q * 2 + e);
        send(26, 1, 0);
        expect_frame("R4 R5 sweep", 1, 4'(q), e[0]);
        if (q == 0 && e == 0) chk("R10 timeout cleared", int'(to), 0);
      end

    // R10: window restarts after strobe
    for (int i = 0; i < TO; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      chk("R10 restart window", int'(to), int'(i == TO - 1));
    end
    build(4'h3, 1, 40); send(24, 1, 0);
    expect_frame("R10 clear frame", 1, 4'h3, 1);
    chk("R10 timeout low", int'(to), 0);

    // R1 R2 R3: corrupt each checked header byte
    for (int b = 0; b < 15; b++) begin
      if (b >= 6 && b < 12) continue;
      build(4'h9, 0, b);
      fr[b] = fr[b] ^ 8'h10;
      send(26, 1, 0);
      expect_frame(b < 6 ? "R1 bad DA" : (b < 14 ? "R2 bad type" : "R3 bad subtype"), 0, 0, 0);
    end
    // R1: source address free
    build(4'h6, 0, 99);
    for (int i = 6; i < 12; i++) fr[i] = 8'hFF;
    send(26, 1, 0);
    expect_frame("R1 any SA", 1, 4'h6, 0);

    // R6
    build(4'hC, 1, 3); send(26, 0, 0);
    expect_frame("R6 bad fcs", 0, 0, 0);

    // R7: length sweep around quality byte
    for (int len = 16; len <= 25; len++) begin
      build(4'(len), len[0], len);
      send(len, 1, 0);
      expect_frame("R7 length", len >= 23, 4'(len), len[0]);
    end

    // R11: gaps
    build(4'hE, 1, 7); send(26, 1, 1);
    expect_frame("R11 gaps", 1, 4'hE, 1);

    // R11: restart marker mid-frame
    build(4'h1, 0, 8);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); valid = 1; data = 8'h55; sof = (i == 0); eof = 0; good = 1;
    end
    send(26, 1, 0);
    expect_frame("R11 restart", 1, 4'h1, 0);

    // R11: stray bytes outside frame ignored then good frame
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); valid = 1; data = 8'h01; sof = 0; eof = (i == 4); good = 1;
    end
    @(negedge clk); valid = 0; eof = 0;
    chk("R11 stray no strobe", int'(stb), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule